// File: doc/BRIEF.md
# Timer Compare Unit with Overflow-Synchronised Shadow

This block watches a free-running timer count that arrives from outside and compares it with one programmable compare value. When the two become equal it updates a single output pin and raises a one-cycle interrupt. Software programs the block through a small write port. That port loads the compare value and, separately, an operating mode and a match level.

There are two operating modes. In set/clear mode, a match drives the pin high and the next timer overflow drives it low again. In this mode the comparison does not use the compare register directly. It uses a shadow copy, and that copy is refreshed only when the timer overflows. A write that is not aligned with the timer therefore cannot drop or double a match inside the current timer period. In level mode, the comparison uses the compare register directly. A match drives the pin to a level that software has chosen, and overflow leaves the pin unchanged.

Top module: `tcmp_top`

## Requirements
- R1: A match occurs when the 16-bit timer count equals the active comparand. In set/clear mode the active comparand is the shadow. In level mode it is the compare register.
- R2: `irq` goes high for exactly one cycle, in the cycle after the first cycle of equality. It does not go high again while the equality continues.
- R3: In set/clear mode (`cfg_mode`=0), a new match makes `out_pin` high in the following cycle. An overflow (`timer_ovf`=1) makes it low in the following cycle. When a match and an overflow fall in the same cycle, the overflow wins.
- R4: The shadow is loaded from the compare register in every cycle with `timer_ovf`=1 and holds its value otherwise. A compare write without an overflow therefore does not change set/clear-mode matching.
- R5: When a compare write (`cfg_we_val`) and an overflow fall in the same cycle, the shadow takes the value being written.
- R6: In level mode (`cfg_mode`=1), a new match drives `out_pin` to the stored level bit in the following cycle.
- R7: In level mode, `timer_ovf` has no effect on `out_pin`.
- R8: Register writes take effect in the next cycle. In level mode, a newly written compare value is matched from the next cycle on.
- R9: During and after reset, `out_pin` and `irq` are low, the compare register, shadow and level are zero, and set/clear mode is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we_val | input | 1 | Write strobe for the compare value |
| cfg_val | input | 16 | Compare value to write |
| cfg_we_mode | input | 1 | Write strobe for mode and level |
| cfg_mode | input | 1 | 0 = set/clear mode, 1 = level mode |
| cfg_level | input | 1 | Pin level applied on a match in level mode |
| timer_cnt | input | 16 | Current timer count |
| timer_ovf | input | 1 | Timer overflow pulse |
| out_pin | output | 1 | Compare output pin |
| irq | output | 1 | Single-cycle interrupt on a new match |

## Verification
The hardest situation to reach from the ports is the one where the shadow and the compare register disagree. This happens after a write that arrives between overflows, and it is made worse when that write coincides with an overflow. The directed part of the stimulus creates exactly these cases. It writes a value, presents that value on the count before any overflow, then overflows and presents it again. It also writes a value in the same cycle as an overflow. The random part biases the count towards the current compare and shadow values so that matches, held matches and match-plus-overflow collisions happen often in both modes.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;
    localparam int TCMP_W = 16;

    typedef enum logic {
        MODE_SETCLR = 1'b0,
        MODE_LEVEL  = 1'b1
    } cmp_mode_e;
endpackage

// File: rtl/tcmp_regs.sv
module tcmp_regs
    import tcmp_pkg::*;
#(
    parameter int W = TCMP_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_val,
    input  logic [W-1:0] wr_val,
    input  logic         we_mode,
    input  cmp_mode_e    wr_mode,
    input  logic         wr_level,
    input  logic         ovf,
    output logic [W-1:0] cmp_o,
    output logic [W-1:0] shadow_o,
    output cmp_mode_e    mode_o,
    output logic         level_o
);
    typedef struct packed {
        logic [W-1:0] cmp;
        logic [W-1:0] shadow;
        cmp_mode_e    mode;
        logic         level;
    } regs_t;

    regs_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (we_val) s_d.cmp = wr_val;
        if (we_mode) begin
            s_d.mode  = wr_mode;
            s_d.level = wr_level;
        end
        if (ovf) s_d.shadow = we_val ? wr_val : s_q.cmp;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{cmp: '0, shadow: '0, mode: MODE_SETCLR, level: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign cmp_o    = s_q.cmp;
    assign shadow_o = s_q.shadow;
    assign mode_o   = s_q.mode;
    assign level_o  = s_q.level;

    assert_shadow_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !we_val) |=> (shadow_o == $past(cmp_o)));
    assert_shadow_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ovf |=> $stable(shadow_o));
    assert_shadow_collide_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && we_val) |=> (shadow_o == $past(wr_val)));
    assert_write_next_R8: assert property (@(posedge clk) disable iff (!rst_n)
        we_val |=> (cmp_o == $past(wr_val)));
endmodule

// File: rtl/tcmp_match.sv
module tcmp_match
    import tcmp_pkg::*;
#(
    parameter int W = TCMP_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] comparand,
    output logic         hit,
    output logic         irq
);
    typedef struct packed {
        logic eq_prev;
        logic irq;
    } match_t;

    match_t m_d, m_q;
    logic   eq_now;

    always_comb begin
        eq_now     = (cnt == comparand);
        hit        = eq_now && !m_q.eq_prev;
        m_d.eq_prev = eq_now;
        m_d.irq     = hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    assign irq = m_q.irq;

    assert_irq_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    assert_irq_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(cnt == comparand));
endmodule

// File: rtl/tcmp_out.sv
module tcmp_out
    import tcmp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      hit,
    input  logic      ovf,
    input  cmp_mode_e mode,
    input  logic      level,
    output logic      out_pin
);
    typedef struct packed {
        logic pin;
    } out_t;

    out_t o_d, o_q;

    always_comb begin
        o_d = o_q;
        if (mode == MODE_SETCLR) begin
            if (ovf)      o_d.pin = 1'b0;
            else if (hit) o_d.pin = 1'b1;
        end else if (hit) begin
            o_d.pin = level;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign out_pin = o_q.pin;

    assert_ovf_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SETCLR && ovf) |=> !out_pin);
    assert_hit_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SETCLR && hit && !ovf) |=> out_pin);
    assert_level_applied_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_LEVEL && hit) |=> (out_pin == $past(level)));
    assert_ovf_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_LEVEL && !hit) |=> $stable(out_pin));
endmodule

// File: rtl/tcmp_top.sv
module tcmp_top
    import tcmp_pkg::*;
#(
    parameter int W = TCMP_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_we_val,
    input  logic [W-1:0] cfg_val,
    input  logic         cfg_we_mode,
    input  logic         cfg_mode,
    input  logic         cfg_level,
    input  logic [W-1:0] timer_cnt,
    input  logic         timer_ovf,
    output logic         out_pin,
    output logic         irq
);
    logic [W-1:0] cmp_q, shadow_q, comparand;
    cmp_mode_e    mode_q;
    logic         level_q;
    logic         hit;

    tcmp_regs #(.W(W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_val   (cfg_we_val),
        .wr_val   (cfg_val),
        .we_mode  (cfg_we_mode),
        .wr_mode  (cmp_mode_e'(cfg_mode)),
        .wr_level (cfg_level),
        .ovf      (timer_ovf),
        .cmp_o    (cmp_q),
        .shadow_o (shadow_q),
        .mode_o   (mode_q),
        .level_o  (level_q)
    );

    assign comparand = (mode_q == MODE_LEVEL) ? cmp_q : shadow_q;

    tcmp_match #(.W(W)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt       (timer_cnt),
        .comparand (comparand),
        .hit       (hit),
        .irq       (irq)
    );

    tcmp_out u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (hit),
        .ovf     (timer_ovf),
        .mode    (mode_q),
        .level   (level_q),
        .out_pin (out_pin)
    );

    assert_reset_state_R9: assert property (@(posedge clk)
        !rst_n |-> (!out_pin && !irq));
endmodule

// File: tb/tb_tcmp_top.sv
module tb_tcmp_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we_val = 1'b0;
    logic [15:0] cfg_val = '0;
    logic        cfg_we_mode = 1'b0;
    logic        cfg_mode = 1'b0;
    logic        cfg_level = 1'b0;
    logic [15:0] timer_cnt = 16'd1;
    logic        timer_ovf = 1'b0;
    logic        out_pin, irq;

    int errors = 0;
    int checks = 0;
    bit auto_on = 1'b0;

    // reference model state
    logic [15:0] m_cmp = '0, m_sh = '0;
    logic        m_mode = 1'b0, m_lvl = 1'b0, m_prev = 1'b0, m_out = 1'b0, m_irq = 1'b0;

    always #5 clk = ~clk;

    tcmp_top dut (
        .clk(clk), .rst_n(rst_n), .cfg_we_val(cfg_we_val), .cfg_val(cfg_val),
        .cfg_we_mode(cfg_we_mode), .cfg_mode(cfg_mode), .cfg_level(cfg_level),
        .timer_cnt(timer_cnt), .timer_ovf(timer_ovf), .out_pin(out_pin), .irq(irq)
    );

    function automatic logic [15:0] active_ref(logic mode, logic [15:0] c, logic [15:0] s);
        return mode ? c : s;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cmp = '0; m_sh = '0; m_mode = 1'b0; m_lvl = 1'b0;
            m_prev = 1'b0; m_out = 1'b0; m_irq = 1'b0;
        end else begin
            automatic logic eq  = (timer_cnt == active_ref(m_mode, m_cmp, m_sh));
            automatic logic new_hit = eq && !m_prev;
            m_irq  = new_hit;
            m_prev = eq;
            if (!m_mode) begin
                if (timer_ovf) m_out = 1'b0;
                else if (new_hit) m_out = 1'b1;
            end else if (new_hit) m_out = m_lvl;
            if (timer_ovf) m_sh = cfg_we_val ? cfg_val : m_cmp;
            if (cfg_we_val) m_cmp = cfg_val;
            if (cfg_we_mode) begin m_mode = cfg_mode; m_lvl = cfg_level; end
        end
    end

    task automatic check(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (auto_on && rst_n) begin
            check(m_mode ? "R6 out(level mode)" : "R3 out(set/clear mode)", out_pin, m_out);
            check("R2 irq", irq, m_irq);
        end
    end

    task automatic step(logic [15:0] cnt, logic ovf);
        timer_cnt = cnt; timer_ovf = ovf;
        @(negedge clk);
        cfg_we_val = 1'b0; cfg_we_mode = 1'b0; timer_ovf = 1'b0;
    endtask

    task automatic wr_val(logic [15:0] v);
        cfg_we_val = 1'b1; cfg_val = v;
    endtask

    task automatic wr_mode(logic md, logic lv);
        cfg_we_mode = 1'b1; cfg_mode = md; cfg_level = lv;
    endtask

    initial begin
        #2000000;
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R9 out in reset", out_pin, 1'b0);
        check("R9 irq in reset", irq, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 out after reset", out_pin, 1'b0);
        auto_on = 1'b1;

        // R4: write without overflow does not affect set/clear matching
        wr_val(16'd100); step(16'd7, 1'b0);
        step(16'd100, 1'b0);
        check("R4 unreloaded shadow, out", out_pin, 1'b0);
        check("R4 unreloaded shadow, irq", irq, 1'b0);
        step(16'd5, 1'b1);                   // shadow <- 100
        step(16'd100, 1'b0);
        check("R1 match after reload, out", out_pin, 1'b1);
        check("R2 irq on first match", irq, 1'b1);
        step(16'd100, 1'b0);
        check("R2 no repeat while equal", irq, 1'b0);
        step(16'd100, 1'b1);
        check("R3 overflow clears", out_pin, 1'b0);
        // R3: match and overflow in the same cycle, overflow wins
        step(16'd3, 1'b0);
        step(16'd100, 1'b1);
        check("R3 overflow beats match", out_pin, 1'b0);
        check("R2 irq on colliding match", irq, 1'b1);

        // R5: write coincides with overflow
        wr_val(16'd200); step(16'd9, 1'b1);
        step(16'd200, 1'b0);
        check("R5 shadow took written value", out_pin, 1'b1);

        // Level mode: R6, R7, R8
        wr_mode(1'b1, 1'b0); step(16'd9, 1'b0);
        step(16'd200, 1'b0);
        check("R6 match drives level 0", out_pin, 1'b0);
        wr_mode(1'b1, 1'b1); step(16'd9, 1'b0);
        step(16'd200, 1'b0);
        check("R6 match drives level 1", out_pin, 1'b1);
        step(16'd9, 1'b1);
        check("R7 overflow ignored", out_pin, 1'b1);
        wr_val(16'd300); wr_mode(1'b1, 1'b0); step(16'd9, 1'b0);
        step(16'd300, 1'b0);
        check("R8 new compare matched at once", out_pin, 1'b0);
        check("R8 irq on new compare", irq, 1'b1);

        // Constrained random phase
        for (int i = 0; i < 4000; i++) begin
            automatic int sel = $urandom_range(0, 9);
            automatic logic [15:0] c;
            if ($urandom_range(0, 15) == 0) wr_val(16'($urandom_range(0, 40)));
            if ($urandom_range(0, 149) == 0) wr_mode(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
            if (sel < 3)      c = m_cmp;
            else if (sel < 6) c = m_sh;
            else              c = 16'($urandom_range(0, 40));
            step(c, ($urandom_range(0, 11) == 0));
        end

        auto_on = 1'b0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule